// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block forms the full double-width unsigned product of two `WIDTH`-bit operands over `WIDTH` clock cycles, using one `WIDTH`-bit adder and a single `2*WIDTH`-bit product register. A start pulse captures both operands. The multiplier is loaded into the lower half of the product register and the upper half is cleared. No separate multiplier register exists: its bits are used up from the right as partial sums shift in from the left.

On each iteration the register's least significant bit decides whether the multiplicand is added into the upper half. The whole register then moves one place to the right, and the adder's carry enters at the top. After exactly `WIDTH` iterations, a one-cycle done pulse marks the result. The result sits on separate upper-half and lower-half outputs and stays there until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both product halves are 0.
- R2: When an operation completes, `{prod_hi, prod_lo}` equals the exact 2*WIDTH-bit unsigned product of the captured operands. `prod_hi` carries the upper WIDTH bits and `prod_lo` the lower WIDTH bits.
- R3: A `start` seen while idle is accepted at that clock edge. `busy` is then 1 for exactly WIDTH cycles, one per add/shift iteration.
- R4: `done` is 1 for exactly one cycle: the first cycle after the last iteration, in which `busy` is already 0.
- R5: While `busy` is 1, `start` and any change on the operand inputs have no effect on the operation in progress or on its result.
- R6: While idle with `start` low, both product halves hold their value whatever the operand inputs do.
- R7: The adder's carry-out is shifted into the top bit of the product, so all-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1.
- R8: A zero operand on either side gives a zero product. An operand of one gives the other operand in `prod_lo` and zero in `prod_hi`.
- R9: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | WIDTH | Operand added on each set bit |
| multiplier | input | WIDTH | Operand whose bits steer the adds |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | WIDTH | Upper half of the product |
| prod_lo | output | WIDTH | Lower half of the product |

## Verification
The bench targets all-ones operands, where a design that dropped the adder's carry would return a product with its top bits wrong. It also covers zero and one operands, where a wrong load of either register half shows up at once as a non-zero or shifted result. It sends start pulses and changed operands in the middle of a run: a design that reloads or re-captures at that point ends with the wrong product or the wrong cycle count. It gives a start in the done cycle and waits idle with changing operands, which catches a design that loses back-to-back starts or lets the product drift while idle.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step_en,
  output logic last_step
);
  import shiftadd_mul_pkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);

  mul_state_e       state_q;
  logic [CNT_W-1:0] left_q;

  assign busy      = (state_q == MUL_RUN);
  assign load      = (state_q == MUL_IDLE) && start;
  assign step_en   = busy;
  assign last_step = step_en && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MUL_IDLE;
      left_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        state_q <= MUL_RUN;
        left_q  <= CNT_W'(WIDTH);
      end else if (step_en) begin
        left_q <= left_q - CNT_W'(1);
        if (last_step) state_q <= MUL_IDLE;
      end
    end
  end

  // R4
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && left_q == CNT_W'(WIDTH)));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && left_q == $past(left_q) - CNT_W'(1)));

endmodule

// File: rtl/shiftadd_mul_datapath.sv
module shiftadd_mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_en,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;

  // named events for checking
  logic             add_sel;
  logic [WIDTH:0]   sum_full;
  logic             sum_carry;
  logic [PW-1:0]    prod_next;

  function automatic logic [WIDTH:0] half_add(input logic [WIDTH-1:0] hi,
                                              input logic [WIDTH-1:0] mc,
                                              input logic             en);
    return {1'b0, hi} + (en ? {1'b0, mc} : '0);
  endfunction

  function automatic logic [PW-1:0] shift_in(input logic [WIDTH:0]   sum,
                                             input logic [WIDTH-1:0] lo);
    return {sum, lo[WIDTH-1:1]};
  endfunction

  assign add_sel   = prod_q[0];
  assign sum_full  = half_add(prod_q[PW-1:WIDTH], mcand_q, add_sel);
  assign sum_carry = sum_full[WIDTH];
  assign prod_next = shift_in(sum_full, prod_q[WIDTH-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= multiplicand;
      prod_q  <= {{WIDTH{1'b0}}, multiplier};
    end else if (step_en) begin
      prod_q <= prod_next;
    end
  end

  assign prod_hi = prod_q[PW-1:WIDTH];
  assign prod_lo = prod_q[WIDTH-1:0];

  // R7
  carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && sum_carry) |=> prod_q[PW-1]);

  // R2
  no_add_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && !add_sel) |=> !prod_q[PW-1]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load) |=> $stable(prod_q));

  // R5
  mcand_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load) |=> $stable(mcand_q));

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  logic load;
  logic step_en;
  logic last_step;

  shiftadd_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .step_en   (step_en),
    .last_step (last_step)
  );

  shiftadd_mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .step_en      (step_en),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .prod_hi      (prod_hi),
    .prod_lo      (prod_lo)
  );

  // R5
  load_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: tb/shiftadd_mul_test.sv
module shiftadd_mul_test;

  localparam int W       = 32;
  localparam int CLK_PER = 10;
  localparam int LIMIT   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] prod_hi;
  logic [W-1:0] prod_lo;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit           m_busy = 1'b0;
  bit           m_done = 1'b0;
  int           m_left = 0;
  logic [2*W-1:0] m_res = '0;

  shiftadd_mul #(.WIDTH(W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .busy         (busy),
    .done         (done),
    .prod_hi      (prod_hi),
    .prod_lo      (prod_lo)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [2*W-1:0] full_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return 64'(a) * 64'(b);
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model, updated at the clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_left = 0; m_res = '0;
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_busy = 1'b0; m_done = 1'b1; end
    end else begin
      m_done = 1'b0;
      if (start) begin m_busy = 1'b1; m_left = W; m_res = full_mul(mcand, mplier); end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 busy", 128'(busy), 128'(m_busy));
      check("R4 done", 128'(done), 128'(m_done));
      if (!m_busy) check("R2 idle product", {prod_hi, prod_lo}, m_res);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
      report();
    end
  end

  // called at a negedge; leaves at the negedge where done is high
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req, input bit noisy);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (noisy) begin
        start = 1'b1; mcand = $urandom(); mplier = $urandom();
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(req, {prod_hi, prod_lo}, full_mul(a, b));
  endtask

  initial begin
    logic [2*W-1:0] held;
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 product", {prod_hi, prod_lo}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 latency: count busy cycles
    mcand = 32'd2; mplier = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (busy) begin lat++; @(negedge clk); end
    check("R3 busy cycles", 128'(lat), 128'(W));
    check("R2 small product", {prod_hi, prod_lo}, 64'd6);
    @(negedge clk);

    run_op(32'h0, 32'hDEADBEEF, "R8 zero mcand", 1'b0);
    run_op(32'h12345678, 32'h0, "R8 zero mplier", 1'b0);
    run_op(32'h1, 32'hCAFEF00D, "R8 one mcand", 1'b0);
    check("R8 one hi zero", 128'(prod_hi), 128'(0));
    run_op(32'h89ABCDEF, 32'h1, "R8 one mplier", 1'b0);
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, "R7 all ones", 1'b0);
    check("R7 top bit", 128'(prod_hi[W-1]), 128'(1));
    run_op(32'hFFFFFFFF, 32'h80000001, "R7 carry mix", 1'b0);

    // R5 start and operand noise during a run
    run_op(32'hA5A5A5A5, 32'h5A5A5A5A, "R5 noisy run", 1'b1);

    // R9 back to back: start issued in the done cycle
    run_op(32'h00000007, 32'h00000009, "R9 first", 1'b0);
    run_op(32'h10000001, 32'hF0000003, "R9 second", 1'b0);

    // R6 hold while idle with operands changing
    held = {prod_hi, prod_lo};
    for (int i = 0; i < 6; i++) begin
      mcand = $urandom(); mplier = $urandom();
      @(negedge clk);
    end
    check("R6 hold", {prod_hi, prod_lo}, held);

    for (int i = 0; i < 20; i++) begin
      run_op($urandom(), $urandom(), "R2 random", (i % 4) == 3);
    end
    @(negedge clk);
    @(negedge clk);
    report();
  end

endmodule